// File: doc/BRIEF.md
# Edge Smoothing Filter with Sliding Sum

This block smooths the pixels on both sides of a block edge when the region around the edge is flat. It receives one line of sixteen pixels that cross the edge, eight on each side, and works in one of two modes. Medium mode uses the eight pixels nearest the edge and rewrites the six inner ones. Wide mode uses all sixteen pixels and rewrites the fourteen inner ones. Each rewritten pixel is a rounded average over a window centred on it. The centre pixel counts twice. Where the window reaches past the used pixels, the outermost used pixel is repeated.

The block does not use one adder tree per output. It keeps a single accumulator. The accumulator is seeded when a job is accepted. It then slides one position per clock: two original samples leave the window and two enter. One filtered pixel is written per cycle. Only the unfiltered copy latched at start feeds the accumulator. Filtered values are held in a separate result register. Deciding whether to filter, and the narrow filter, belong to neighbouring logic. The caller supplies a per-mode enable instead.

A job starts with a one-cycle `start` pulse while the block is idle. `done` pulses once when the result vector is complete.

Top module: `flat_smooth_rsum`

## Requirements
- R1: While reset is held, and after it is released, `busy`, `done` and every bit of `pix_out` are 0.
- R2: Lane k of `pix_in`/`pix_out` is bits [k*BW +: BW]. Lane 0 is the outermost pixel on the near side, lane 7 is nearest the edge on that side, lane 8 is nearest the edge on the far side, and lane 15 is outermost on the far side. In medium mode (`wide_sel`=0) the samples are x[j] = lane 4+j, for j = 0..7. For i = 1..6, lane 4+i becomes (x[c(i-3)] + ... + x[c(i+3)] + x[i] + 4) >> 3, where c() clamps the index to 0..7. All terms use the values latched at start.
- R3: In wide mode (`wide_sel`=1) the samples are x[j] = lane j, for j = 0..15. For i = 1..14, lane i becomes (x[c(i-7)] + ... + x[c(i+7)] + x[i] + 8) >> 4, where c() clamps the index to 0..15. All terms use the values latched at start.
- R4: Lanes that a mode does not rewrite come out equal to the latched input. In medium mode these are lanes 0..4 and 11..15. In wide mode they are lanes 0 and 15.
- R5: The enable is sampled with `start`: `en_wide` in wide mode, `en_med` in medium mode. When that enable is 0, `pix_out` equals the latched input in every lane.
- R6: When every input is 2^BW-1, every output is 2^BW-1 in both modes. The accumulator never exceeds 16*(2^BW-1)+8.
- R7: Call the clock edge that samples an accepted `start` edge 0. `busy` is high from after edge 0 until the last pixel is written. `done` is high for exactly one cycle, starting 7 cycles after edge 0 in medium mode and 15 in wide mode, and `busy` is low in that cycle.
- R8: A `start` that arrives while `busy` is high is ignored. The running job keeps its mode, data, latency and result.
- R9: A `start` given in the cycle where `done` is high is accepted, so jobs can run back to back.
- R10: Between `done` and the next accepted `start`, `pix_out` holds its value whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a job; accepted only while idle |
| wide_sel | input | 1 | 1 selects wide mode, 0 selects medium mode |
| en_med | input | 1 | Allow rewriting in medium mode |
| en_wide | input | 1 | Allow rewriting in wide mode |
| pix_in | input | 16*BW | Sixteen pixels crossing the edge, lane 0 in the LSBs |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle pulse when the result is complete |
| pix_out | output | 16*BW | Result vector |

## Verification
The end of one job and the start of the next can fall in the same cycle. A fresh `start` is presented exactly in the cycle where `done` is high. The bench then checks that the second job's latency is counted from that cycle and that its result matches its own data. A second overlap case sends a `start` with different data and a different mode into the middle of a medium job. That job must keep its latency and its result. Expected vectors come from a direct windowed average computed in the bench, not from a running sum.

// File: rtl/flat_rsum_pkg.sv
package flat_rsum_pkg;
   localparam int NLANES = 16;
   localparam int LANE_W = $clog2(NLANES);
   localparam int HALF_WIDE = NLANES / 2;
   localparam int HALF_MED = NLANES / 4;
   localparam int PAD_MED = HALF_WIDE - HALF_MED;
   typedef logic [LANE_W-1:0] lane_t;
endpackage

// File: rtl/flat_rsum_seed.sv
module flat_rsum_seed
   import flat_rsum_pkg::*;
#(
   parameter int BW = 12,
   parameter int SW = BW + LANE_W + 1
) (
   input  logic [NLANES*BW-1:0] pix,
   input  logic                 wide_sel,
   output logic [SW-1:0]        seed
);
   logic [SW-1:0] acc_m [2];

   for (genvar m = 0; m < 2; m++) begin : g_mode
      localparam int H = (m == 1) ? HALF_WIDE : HALF_MED;
      localparam int B = HALF_WIDE - H;
      always_comb begin
         acc_m[m] = SW'(H) + SW'(H - 1) * SW'(pix[B*BW +: BW]);
         acc_m[m] = acc_m[m] + SW'(pix[(B+1)*BW +: BW]);
         for (int k = 1; k <= H; k++) begin
            acc_m[m] = acc_m[m] + SW'(pix[(B+k)*BW +: BW]);
         end
      end
   end

   assign seed = wide_sel ? acc_m[1] : acc_m[0];
endmodule

// File: rtl/flat_rsum_ctrl.sv
module flat_rsum_ctrl
   import flat_rsum_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  start,
   input  logic  wide_sel,
   output logic  accept,
   output logic  busy,
   output logic  done,
   output logic  wide_q,
   output lane_t cur,
   output lane_t lo,
   output lane_t hi
);
   lane_t first_l, last_l, pad_l, pad_r;
   int    half, ci;

   assign accept  = start & ~busy;
   assign first_l = wide_q ? lane_t'(1) : lane_t'(PAD_MED + 1);
   assign last_l  = wide_q ? lane_t'(NLANES - 2) : lane_t'(NLANES - 2 - PAD_MED);
   assign pad_l   = wide_q ? lane_t'(0) : lane_t'(PAD_MED);
   assign pad_r   = wide_q ? lane_t'(NLANES - 1) : lane_t'(NLANES - 1 - PAD_MED);

   always_comb begin
      half = wide_q ? HALF_WIDE : HALF_MED;
      ci   = int'(cur);
      lo   = (ci - (half - 1) < int'(pad_l)) ? pad_l : lane_t'(ci - (half - 1));
      hi   = (ci + half > int'(pad_r)) ? pad_r : lane_t'(ci + half);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         done   <= 1'b0;
         wide_q <= 1'b0;
         cur    <= '0;
      end else if (accept) begin
         busy   <= 1'b1;
         done   <= 1'b0;
         wide_q <= wide_sel;
         cur    <= wide_sel ? lane_t'(1) : lane_t'(PAD_MED + 1);
      end else if (busy) begin
         if (cur == last_l) begin
            busy <= 1'b0;
            done <= 1'b1;
         end else begin
            cur  <= cur + lane_t'(1);
            done <= 1'b0;
         end
      end else begin
         done <= 1'b0;
      end
   end

   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   assert_lane_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cur >= first_l && cur <= last_l));
endmodule

// File: rtl/flat_rsum_slide.sv
module flat_rsum_slide
   import flat_rsum_pkg::*;
#(
   parameter int BW = 12,
   parameter int SW = BW + LANE_W + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic                 step,
   input  logic [SW-1:0]        seed,
   input  logic [NLANES*BW-1:0] orig,
   input  lane_t                cur,
   input  lane_t                lo,
   input  lane_t                hi,
   output logic [SW-1:0]        sum_q
);
   localparam logic [SW-1:0] MAX_SUM = SW'(NLANES * ((1 << BW) - 1) + HALF_WIDE);

   lane_t         nxt;
   logic [SW-1:0] sum_nxt;

   assign nxt = cur + lane_t'(1);
   assign sum_nxt = sum_q
                  - SW'(orig[lo*BW +: BW]) - SW'(orig[cur*BW +: BW])
                  + SW'(orig[hi*BW +: BW]) + SW'(orig[nxt*BW +: BW]);

   always_ff @(posedge clk) begin
      if (!rst_n)    sum_q <= '0;
      else if (load) sum_q <= seed;
      else if (step) sum_q <= sum_nxt;
   end

   assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sum_q <= MAX_SUM);
endmodule

// File: rtl/flat_smooth_rsum.sv
module flat_smooth_rsum
   import flat_rsum_pkg::*;
#(
   parameter int BW = 12
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic                 wide_sel,
   input  logic                 en_med,
   input  logic                 en_wide,
   input  logic [NLANES*BW-1:0] pix_in,
   output logic                 busy,
   output logic                 done,
   output logic [NLANES*BW-1:0] pix_out
);
   localparam int SW   = BW + LANE_W + 1;
   localparam int SH_W = LANE_W;
   localparam int SH_M = LANE_W - 1;

   if (BW < 2 || BW > 16) begin : g_bad_bw
      $error("flat_smooth_rsum: BW must be 2..16");
   end

   logic                 accept, wide_q, apply_q;
   lane_t                cur, lo, hi;
   logic [SW-1:0]        seed, sum_q;
   logic [NLANES*BW-1:0] orig_q, res_q;
   logic [BW-1:0]        filt;

   flat_rsum_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .wide_sel(wide_sel),
      .accept(accept), .busy(busy), .done(done), .wide_q(wide_q),
      .cur(cur), .lo(lo), .hi(hi)
   );

   flat_rsum_seed #(.BW(BW), .SW(SW)) u_seed (
      .pix(pix_in), .wide_sel(wide_sel), .seed(seed)
   );

   flat_rsum_slide #(.BW(BW), .SW(SW)) u_slide (
      .clk(clk), .rst_n(rst_n), .load(accept), .step(busy), .seed(seed),
      .orig(orig_q), .cur(cur), .lo(lo), .hi(hi), .sum_q(sum_q)
   );

   assign filt = wide_q ? BW'(sum_q >> SH_W) : BW'(sum_q >> SH_M);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         orig_q  <= '0;
         res_q   <= '0;
         apply_q <= 1'b0;
      end else if (accept) begin
         orig_q  <= pix_in;
         res_q   <= pix_in;
         apply_q <= wide_sel ? en_wide : en_med;
      end else if (busy && apply_q) begin
         res_q[cur*BW +: BW] <= filt;
      end
   end

   assign pix_out = res_q;

   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(pix_out));
   assert_ignore_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> ($stable(orig_q) && $stable(wide_q)));
   assert_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !apply_q) |=> $stable(pix_out));
endmodule

// File: tb/flat_smooth_rsum_tb.sv
`timescale 1ns/1ps
module flat_smooth_rsum_tb;
   localparam int BW = 12;
   localparam int NB = 16 * BW;

   localparam logic [NB-1:0] PIXTAB [5] = '{
      192'h800800800800800800800800800800800800800800800800,
      192'hF00E00D00C00B00A00900800700600500400300200100000,
      192'hFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFF,
      192'hE00E00E00E00E00E00E00E00100100100100100100100100,
      192'h123ABC4569870FE3216548ACDEF0102DEAD0BEE0CAF0F077
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          wide_sel = 1'b0;
   logic          en_med = 1'b0;
   logic          en_wide = 1'b0;
   logic [NB-1:0] pix_in = '0;
   logic          busy, done;
   logic [NB-1:0] pix_out;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #2.5 clk = ~clk;

   flat_smooth_rsum #(.BW(BW)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .wide_sel(wide_sel),
      .en_med(en_med), .en_wide(en_wide), .pix_in(pix_in),
      .busy(busy), .done(done), .pix_out(pix_out)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 20000) begin
         errors = errors + 1;
         checks = checks + 1;
         $display("FAIL watchdog: run hung, actual cycles %0d expected < 20000", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   function automatic logic [NB-1:0] ref_filter(input logic [NB-1:0] px, input bit wide, input bit en);
      int h, b, sh, acc, c;
      logic [NB-1:0] r;
      r = px;
      h = wide ? 8 : 4;
      b = 8 - h;
      sh = wide ? 4 : 3;
      if (en) begin
         for (int i = 1; i <= 2*h - 2; i++) begin
            acc = h + int'(px[(b+i)*BW +: BW]);
            for (int j = i - (h - 1); j <= i + h - 1; j++) begin
               c = (j < 0) ? 0 : ((j > 2*h - 1) ? 2*h - 1 : j);
               acc = acc + int'(px[(b+c)*BW +: BW]);
            end
            r[(b+i)*BW +: BW] = BW'(acc >> sh);
         end
      end
      return r;
   endfunction

   task automatic check_vec(input string tag, input logic [NB-1:0] act, input logic [NB-1:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         errors = errors + 1;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic check_int(input string tag, input int act, input int exp);
      checks = checks + 1;
      if (act != exp) begin
         errors = errors + 1;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Called at a falling edge; returns at the falling edge where done is seen.
   task automatic launch(input logic [NB-1:0] px, input bit wide, input bit en, output int lat);
      pix_in = px;
      wide_sel = wide;
      en_med = en;
      en_wide = en;
      start = 1'b1;
      lat = 1;
      @(negedge clk);
      start = 1'b0;
      while (!done && lat < 100) begin
         @(negedge clk);
         lat++;
      end
   endtask

   initial begin
      int lat;
      logic [NB-1:0] held;
      repeat (3) @(negedge clk);
      // R1: reset state while held and after release
      check_int("R1 busy in reset", int'(busy), 0);
      check_int("R1 done in reset", int'(done), 0);
      check_vec("R1 pix_out in reset", pix_out, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check_vec("R1 pix_out after release", pix_out, '0);

      // Table walk: every vector in both modes, filtering enabled
      for (int t = 0; t < 5; t++) begin
         for (int m = 0; m < 2; m++) begin
            launch(PIXTAB[t], bit'(m), 1'b1, lat);
            if (m == 1) check_vec("R3 wide result", pix_out, ref_filter(PIXTAB[t], 1'b1, 1'b1));
            else        check_vec("R2 medium result", pix_out, ref_filter(PIXTAB[t], 1'b0, 1'b1));
            check_int("R7 latency", lat, (m == 1) ? 15 : 7);
            check_int("R7 busy low with done", int'(busy), 0);
            @(negedge clk);
            check_int("R7 done single cycle", int'(done), 0);
         end
      end

      // R6: saturated input, both modes
      launch(PIXTAB[2], 1'b1, 1'b1, lat);
      check_vec("R6 max input wide", pix_out, {16{12'hFFF}});
      @(negedge clk);
      launch(PIXTAB[2], 1'b0, 1'b1, lat);
      check_vec("R6 max input medium", pix_out, {16{12'hFFF}});
      @(negedge clk);

      // R4: untouched lanes
      launch(PIXTAB[4], 1'b0, 1'b1, lat);
      check_vec("R4 medium outer near lanes", {132'(0), pix_out[5*BW-1:0]}, {132'(0), PIXTAB[4][5*BW-1:0]});
      check_vec("R4 medium outer far lanes", {132'(0), pix_out[NB-1:11*BW]}, {132'(0), PIXTAB[4][NB-1:11*BW]});
      @(negedge clk);
      launch(PIXTAB[4], 1'b1, 1'b1, lat);
      check_int("R4 wide lane 0", int'(pix_out[BW-1:0]), int'(PIXTAB[4][BW-1:0]));
      check_int("R4 wide lane 15", int'(pix_out[NB-1 -: BW]), int'(PIXTAB[4][NB-1 -: BW]));
      @(negedge clk);

      // R5: enable low gives the input back
      launch(PIXTAB[3], 1'b0, 1'b0, lat);
      check_vec("R5 medium disabled", pix_out, PIXTAB[3]);
      @(negedge clk);
      launch(PIXTAB[4], 1'b1, 1'b0, lat);
      check_vec("R5 wide disabled", pix_out, PIXTAB[4]);
      @(negedge clk);

      // R8: start during a medium job with other data and mode
      pix_in = PIXTAB[1];
      wide_sel = 1'b0;
      en_med = 1'b1;
      start = 1'b1;
      lat = 1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk); lat++;
      @(negedge clk); lat++;
      pix_in = PIXTAB[4];
      wide_sel = 1'b1;
      en_wide = 1'b1;
      start = 1'b1;
      @(negedge clk); lat++;
      start = 1'b0;
      while (!done && lat < 100) begin
         @(negedge clk);
         lat++;
      end
      check_int("R8 latency kept", lat, 7);
      check_vec("R8 result kept", pix_out, ref_filter(PIXTAB[1], 1'b0, 1'b1));
      @(negedge clk);

      // R9: new start in the done cycle
      launch(PIXTAB[3], 1'b0, 1'b1, lat);
      check_int("R9 first job done seen", int'(done), 1);
      launch(PIXTAB[4], 1'b1, 1'b1, lat);
      check_int("R9 back-to-back latency", lat, 15);
      check_vec("R9 back-to-back result", pix_out, ref_filter(PIXTAB[4], 1'b1, 1'b1));
      held = pix_out;

      // R10: result holds while idle with changing inputs
      pix_in = PIXTAB[0];
      wide_sel = 1'b0;
      en_med = 1'b0;
      repeat (5) @(negedge clk);
      check_vec("R10 hold while idle", pix_out, held);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule